// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Reader

This block serves byte reads from a memory window that is backed by serial flash devices. A requester gives a byte address and a one-cycle read strobe. The upper address bits choose the device, because every device owns a window of equal size. The block then runs a complete flash read on the SPI pins: an opcode, an address, optional dummy clocks, and a burst of data bytes. Each received byte comes back on a byte bus with a one-cycle valid strobe.

A single 32-bit configuration word covers every mapped read. It sets the opcode, the number of address bytes (3 or 4), the lane width of the address and data phases (one, two or four lines), the dummy length and the burst length. The opcode is always sent on one line. A lock bit freezes the word until the next reset. The block captures the configuration when it accepts a request, so a write made during a transfer only affects later reads.

Top module: `spi_flash_mmap_reader`

## Requirements
- R1: While reset is active and right after it, every chip select is high, SCLK is low, busy and rd_valid are low, rd_data is 0 and cfg_q reads 32'h0000_0003 (opcode 03h, single line, 3 address bytes, no dummy, 1-byte burst, unlocked).
- R2: A cfg_we pulse loads cfg_wdata into cfg_q at the next edge while cfg_q bit 31 is 0. Once bit 31 is 1, every later write is ignored until reset.
- R3: The device index is rd_addr[WIN_BITS+CSW-1:WIN_BITS]. Only spi_cs_n of that index goes low, and it stays low for the whole transfer while all the others stay high.
- R4: SPI mode 0. SCLK idles low and each SCLK period lasts two clk cycles, low then high. Outputs change only as SCLK falls. Chip select falls one clk before the first rising edge and rises as SCLK falls after the last data bit.
- R5: The command phase sends cfg bits 7:0 MSB-first on spi_io_o[0] over 8 periods with spi_io_oe = 4'b0001, whatever the lane width.
- R6: Address bytes are 3 when cfg bits 17:16 are 0 (window offset bits 23:0) and 4 otherwise (offset zero-extended to 32 bits). The lane width in cfg bits 9:8 is 0 for one line (io[0]), 1 for two lines (io[1:0]), 2 for four lines (io[3:0]); code 3 acts as one line. Address bits go out MSB-first, and the higher-numbered lane carries the more significant bit.
- R7: A dummy phase of D*8/W periods follows the address, where D is cfg bits 13:12 and W is the lane count. All io enables are 0 during it, and there is no dummy phase when D is 0.
- R8: During the data phase the IO enables are 0. Input is sampled on each SCLK rising edge: from io[1] for one line, io[1:0] for two lines, io[3:0] for four lines, MSB-first. Each completed byte appears on rd_data with a one-cycle rd_valid, in rising address order, in the clk cycle in which SCLK falls after its last bit.
- R9: The burst length comes from cfg bits 25:24: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 16.
- R10: A request is accepted only while busy is low. Busy goes high on the next cycle and falls with the chip-select release. A strobe while busy is ignored.
- R11: The configuration is captured at acceptance. A cfg write during a transfer does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_q | output | 32 | Current configuration word |
| rd_req | input | 1 | Read strobe |
| rd_addr | input | WIN_BITS+CSW | Byte address in the mapped space |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle strobe per received byte |
| rd_data | output | 8 | Received byte |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_o | output | 4 | IO line output values |
| spi_io_oe | output | 4 | IO line output enables |
| spi_io_i | input | 4 | IO line input values |

## Verification
A wrong phase counter or shift register inside the block shows on spi_io_o or spi_io_oe within the SCLK period in which it goes wrong. The bench compares the pins against its model on every clk cycle, so a misplaced opcode, address or dummy boundary is caught two cycles after the fault at the latest. A wrong lane width or group count inside a byte shows as a wrong rd_data value, or as an rd_valid strobe one period early or late. A wrong latched device index shows as the wrong spi_cs_n line low in the first cycle of the transfer.

// File: rtl/spi_flash_mmap_reader.sv
module spi_flash_mmap_reader #(
  parameter int WIN_BITS = 27,
  parameter int NUM_CS = 4,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int AW = WIN_BITS + CSW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_q,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  output logic              busy,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [3:0]        spi_io_o,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_i
);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUM, S_DATA} st_t;

  st_t            st;
  logic           ph;
  logic [7:0]     cnt;
  logic [2:0]     grp;
  logic [39:0]    sh;
  logic [7:0]     ish;
  logic [1:0]     lg;
  logic           ab4;
  logic [1:0]     dum;
  logic [1:0]     blen;
  logic [CSW-1:0] dev;

  logic [1:0]     c_lg;
  logic [CSW-1:0] req_dev;
  logic [31:0]    req_off;
  logic [31:0]    req_abytes;
  logic [7:0]     n_addr;
  logic [7:0]     n_dum;
  logic [7:0]     n_bits;
  logic [7:0]     n_data;
  logic [2:0]     grp_last;
  logic [7:0]     ish_next;

  assign c_lg       = (cfg_q[9:8] == 2'd1) ? 2'd1 : (cfg_q[9:8] == 2'd2) ? 2'd2 : 2'd0;
  assign req_dev    = rd_addr[AW-1 -: CSW];
  assign req_off    = 32'(rd_addr[WIN_BITS-1:0]);
  assign req_abytes = (cfg_q[17:16] != 2'd0) ? req_off : {req_off[23:0], 8'h00};

  assign n_addr   = (ab4 ? 8'd32 : 8'd24) >> lg;
  assign n_dum    = {3'b000, dum, 3'b000} >> lg;
  assign n_data   = n_bits >> lg;
  assign grp_last = 3'd7 >> lg;

  always_comb begin
    case (blen)
      2'd0:    n_bits = 8'd8;
      2'd1:    n_bits = 8'd32;
      2'd2:    n_bits = 8'd64;
      default: n_bits = 8'd128;
    endcase
  end

  always_comb begin
    case (lg)
      2'd2:    ish_next = {ish[3:0], spi_io_i[3:0]};
      2'd1:    ish_next = {ish[5:0], spi_io_i[1:0]};
      default: ish_next = {ish[6:0], spi_io_i[1]};
    endcase
  end

  always_comb begin
    spi_io_o  = 4'b0000;
    spi_io_oe = 4'b0000;
    if (st == S_CMD) begin
      spi_io_o  = {3'b000, sh[39]};
      spi_io_oe = 4'b0001;
    end else if (st == S_ADDR) begin
      case (lg)
        2'd2: begin
          spi_io_o  = sh[39:36];
          spi_io_oe = 4'b1111;
        end
        2'd1: begin
          spi_io_o  = {2'b00, sh[39:38]};
          spi_io_oe = 4'b0011;
        end
        default: begin
          spi_io_o  = {3'b000, sh[39]};
          spi_io_oe = 4'b0001;
        end
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign spi_sclk = ph;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !(busy && (dev == CSW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 32'h0000_0003;
    end else if (cfg_we && !cfg_q[31]) begin
      cfg_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      cnt      <= 8'd0;
      grp      <= 3'd0;
      sh       <= 40'd0;
      ish      <= 8'd0;
      lg       <= 2'd0;
      ab4      <= 1'b0;
      dum      <= 2'd0;
      blen     <= 2'd0;
      dev      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= 8'd0;
    end else begin
      rd_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (rd_req) begin
          st   <= S_CMD;
          ph   <= 1'b0;
          cnt  <= 8'd7;
          grp  <= 3'd0;
          sh   <= {cfg_q[7:0], req_abytes};
          lg   <= c_lg;
          ab4  <= |cfg_q[17:16];
          dum  <= cfg_q[13:12];
          blen <= cfg_q[25:24];
          dev  <= req_dev;
        end
      end else if (!ph) begin
        ph <= 1'b1;
        if (st == S_DATA) ish <= ish_next;
      end else begin
        ph <= 1'b0;
        if (st == S_CMD) begin
          sh <= {sh[38:0], 1'b0};
        end else if (st == S_ADDR) begin
          case (lg)
            2'd2:    sh <= {sh[35:0], 4'b0000};
            2'd1:    sh <= {sh[37:0], 2'b00};
            default: sh <= {sh[38:0], 1'b0};
          endcase
        end else if (st == S_DATA) begin
          if (grp == grp_last) begin
            grp      <= 3'd0;
            rd_valid <= 1'b1;
            rd_data  <= ish;
          end else begin
            grp <= grp + 3'd1;
          end
        end
        if (cnt != 8'd0) begin
          cnt <= cnt - 8'd1;
        end else begin
          case (st)
            S_CMD: begin
              st  <= S_ADDR;
              cnt <= n_addr - 8'd1;
            end
            S_ADDR: begin
              if (dum != 2'd0) begin
                st  <= S_DUM;
                cnt <= n_dum - 8'd1;
              end else begin
                st  <= S_DATA;
                cnt <= n_data - 8'd1;
              end
            end
            S_DUM: begin
              st  <= S_DATA;
              cnt <= n_data - 8'd1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

endmodule

module spi_flash_mmap_reader_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_q,
  input logic              rd_req,
  input logic              busy,
  input logic              rd_valid,
  input logic              spi_sclk,
  input logic [NUM_CS-1:0] spi_cs_n,
  input logic [3:0]        spi_io_o,
  input logic [3:0]        spi_io_oe
);

  // R3
  one_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R3
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&spi_cs_n) && $past(!(&spi_cs_n))) |-> $stable(spi_cs_n));

  // R4
  clk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !(&spi_cs_n));

  // R4
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |=> !spi_sclk);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> ($stable(spi_io_o) && $stable(spi_io_oe)));

  // R5
  drive_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|spi_io_oe) |-> !(&spi_cs_n));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_q[31]) |-> $stable(cfg_q));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |=> busy);

endmodule

bind spi_flash_mmap_reader spi_flash_mmap_reader_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_q     (cfg_q),
  .rd_req    (rd_req),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_io_o  (spi_io_o),
  .spi_io_oe (spi_io_oe)
);

// File: tb/test_spi_flash_mmap_reader.sv
module test_spi_flash_mmap_reader;
  localparam int WIN_BITS = 27;
  localparam int NUM_CS = 4;
  localparam int AW = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = 32'd0;
  logic [31:0]   cfg_q;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          spi_sclk;
  logic [3:0]    spi_cs_n;
  logic [3:0]    spi_io_o;
  logic [3:0]    spi_io_oe;
  logic [3:0]    io_in = 4'd0;

  spi_flash_mmap_reader #(.WIN_BITS(WIN_BITS), .NUM_CS(NUM_CS)) i_spi_flash_mmap_reader (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe),
    .spi_io_i(io_in));

  typedef struct packed {
    logic       bsy;
    logic       vld;
    logic [7:0] dat;
    logic       sclk;
    logic [3:0] csn;
    logic [3:0] oe;
    logic [3:0] o;
    logic [3:0] tag;
  } rec_t;

  rec_t        q[$];
  rec_t        e;
  int          n_cmp = 0;
  int          n_bad = 0;
  string       ctx = "reset";
  logic [31:0] exp_cfg;
  logic        pend_v = 1'b0;
  logic [7:0]  pend_d = 8'd0;

  // flash device model
  int          f_r = 0, f_pre = 1000, f_lg = 0, f_cs = 0;
  int          fg, fw, fgpb;
  logic [31:0] f_a = 32'd0, f_mask = 32'hFFFFFF;
  logic [7:0]  fb, fs;

  function automatic logic [7:0] fbyte(input int cs, input logic [31:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'(cs * 91) ^ 8'hA6 ^ a[31:24];
  endfunction

  function automatic logic [31:0] mkcfg(input logic lock, input logic [1:0] burst,
      input logic [1:0] asz, input logic [1:0] dm, input logic [1:0] acc, input logic [7:0] op);
    return {lock, 5'b0, burst, 6'b0, asz, 2'b0, dm, 2'b0, acc, op};
  endfunction

  always @(posedge spi_sclk) f_r = f_r + 1;

  always @(negedge spi_sclk) begin
    if (f_r >= f_pre) begin
      fg   = f_r - f_pre;
      fw   = 1 << f_lg;
      fgpb = 8 / fw;
      fb   = fbyte(f_cs, (f_a + 32'(fg / fgpb)) & f_mask);
      fs   = fb << (fw * (fg % fgpb));
      case (f_lg)
        0:       io_in = {2'b00, fs[7], 1'b0};
        1:       io_in = {2'b00, fs[7:6]};
        default: io_in = fs[7:4];
      endcase
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_cfg <= 32'h0000_0003;
    else if (cfg_we && !exp_cfg[31]) exp_cfg <= cfg_wdata;
  end

  task automatic check(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s [%s]: actual %h expected %h at %0t", r, what, ctx, act, exp, $time);
    end
  endtask

  function automatic string tagname(input logic [3:0] t);
    case (t)
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R4";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0) e = q.pop_front();
      else e = '{bsy: 1'b0, vld: 1'b0, dat: 8'd0, sclk: 1'b0, csn: 4'hF, oe: 4'h0, o: 4'h0, tag: 4'd0};
      check("R3", "cs_n", 32'(spi_cs_n), 32'(e.csn));
      check("R4", "sclk", 32'(spi_sclk), 32'(e.sclk));
      check(tagname(e.tag), "io oe/out", 32'({spi_io_oe, spi_io_o}), 32'({e.oe, e.o}));
      check("R10", "busy", 32'(busy), 32'(e.bsy));
      check("R8 R9", "rd_valid", 32'(rd_valid), 32'(e.vld));
      if (e.vld) check("R8", "rd_data", 32'(rd_data), 32'(e.dat));
      check("R2", "cfg_q", cfg_q, exp_cfg);
    end
  end

  task automatic push_per(input logic [3:0] csn, input logic [3:0] oe, input logic [3:0] o, input logic [3:0] t);
    q.push_back('{bsy: 1'b1, vld: pend_v, dat: pend_d, sclk: 1'b0, csn: csn, oe: oe, o: o, tag: t});
    q.push_back('{bsy: 1'b1, vld: 1'b0, dat: 8'd0, sclk: 1'b1, csn: csn, oe: oe, o: o, tag: t});
    pend_v = 1'b0;
  endtask

  task automatic push_idle();
    q.push_back('{bsy: 1'b0, vld: pend_v, dat: pend_d, sclk: 1'b0, csn: 4'hF, oe: 4'h0, o: 4'h0, tag: 4'd0});
    pend_v = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) step();
  endtask

  // Called just after a clock edge, with the model queue empty.
  task automatic rd(input int cs, input logic [31:0] off);
    logic [31:0] c, a, aa;
    logic [3:0]  csn, oem, o;
    int          lg, w, ab, d, len, na;
    c    = exp_cfg;
    lg   = (c[9:8] == 2'd1) ? 1 : (c[9:8] == 2'd2) ? 2 : 0;
    w    = 1 << lg;
    ab   = (c[17:16] != 2'd0) ? 4 : 3;
    d    = int'(c[13:12]);
    len  = (c[25:24] == 2'd0) ? 1 : (c[25:24] == 2'd1) ? 4 : (c[25:24] == 2'd2) ? 8 : 16;
    a    = (ab == 4) ? off : (off & 32'hFF_FFFF);
    aa   = (ab == 4) ? a : (a << 8);
    csn  = ~(4'b0001 << cs);
    oem  = 4'((1 << w) - 1);
    na   = ab * 8 / w;
    f_r    = 0;
    f_pre  = 8 + na + d * 8 / w;
    f_lg   = lg;
    f_cs   = cs;
    f_a    = a;
    f_mask = (ab == 4) ? 32'hFFFF_FFFF : 32'hFF_FFFF;
    push_idle();
    for (int p = 0; p < 8; p++) push_per(csn, 4'b0001, {3'b000, c[7-p]}, 4'd5);
    for (int p = 0; p < na; p++) begin
      o = 4'd0;
      for (int j = 0; j < w; j++) o[j] = aa[31 - (p * w + (w - 1 - j))];
      push_per(csn, oem, o, 4'd6);
    end
    for (int p = 0; p < d * 8 / w; p++) push_per(csn, 4'd0, 4'd0, 4'd7);
    for (int k = 0; k < len; k++) begin
      for (int g = 0; g < 8 / w; g++) push_per(csn, 4'd0, 4'd0, 4'd8);
      pend_v = 1'b1;
      pend_d = fbyte(cs, (a + 32'(k)) & f_mask);
    end
    push_idle();
    rd_req  = 1'b1;
    rd_addr = {2'(cs), off[WIN_BITS-1:0]};
    step();
    rd_req  = 1'b0;
  endtask

  task automatic wcfg(input logic [31:0] v);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    step();
    cfg_we    = 1'b0;
  endtask

  task automatic chk_reset();
    @(negedge clk);
    // R1
    check("R1", "cs_n in reset", 32'(spi_cs_n), 32'hF);
    check("R1", "sclk in reset", 32'(spi_sclk), 32'd0);
    check("R1", "busy in reset", 32'(busy), 32'd0);
    check("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
    check("R1", "rd_data in reset", 32'(rd_data), 32'd0);
    check("R1", "cfg_q in reset", cfg_q, 32'h0000_0003);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    chk_reset();
    chk_reset();
    step();
    rst_n = 1'b1;
    repeat (3) step();

    ctx = "R5 R6 default single-line read";
    rd(0, 32'h012_3456);
    wait_idle();

    ctx = "R6 R7 R9 two-line, one dummy byte, 4-byte burst";
    wcfg(mkcfg(1'b0, 2'd1, 2'd0, 2'd1, 2'd1, 8'h3B));
    rd(1, 32'h5A5_A5A5);
    wait_idle();

    ctx = "R6 R7 R9 four-line, 4-byte address, 3 dummy, 16-byte burst";
    wcfg(mkcfg(1'b0, 2'd3, 2'd1, 2'd3, 2'd2, 8'hEB));
    rd(3, 32'h7FF_FFF8);
    wait_idle();
    ctx = "R3 R10 back-to-back on another device";
    rd(2, 32'h000_0010);
    wait_idle();

    ctx = "R6 R9 code 3 acts as one line, 8-byte burst";
    wcfg(mkcfg(1'b0, 2'd2, 2'd1, 2'd2, 2'd3, 8'h0B));
    rd(2, 32'h1234_567);
    wait_idle();

    ctx = "R6 R7 four-line, no dummy, 3-byte truncation";
    wcfg(mkcfg(1'b0, 2'd0, 2'd0, 2'd0, 2'd2, 8'h6B));
    rd(1, 32'h7AB_CDEF);
    wait_idle();

    ctx = "R10 R11 strobe while busy, config written mid-transfer";
    wcfg(mkcfg(1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 8'h03));
    rd(0, 32'h000_0100);
    repeat (4) step();
    wcfg(mkcfg(1'b0, 2'd0, 2'd1, 2'd3, 2'd2, 8'hC3));
    repeat (4) step();
    rd_req  = 1'b1;
    rd_addr = {2'd3, 27'h0000_055};
    step();
    rd_req  = 1'b0;
    wait_idle();
    repeat (4) step();

    ctx = "R2 lock bit freezes configuration";
    wcfg(mkcfg(1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 8'hBB));
    step();
    wcfg(mkcfg(1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'h03));
    check("R2", "cfg_q after locked write", cfg_q, mkcfg(1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 8'hBB));
    rd(3, 32'h00A_BC00);
    wait_idle();

    ctx = "R1 R2 reset clears lock";
    rst_n = 1'b0;
    chk_reset();
    chk_reset();
    step();
    rst_n = 1'b1;
    repeat (2) step();
    wcfg(mkcfg(1'b0, 2'd1, 2'd0, 2'd1, 2'd2, 8'hEB));
    step();
    check("R2", "cfg_q write after reset", cfg_q, mkcfg(1'b0, 2'd1, 2'd0, 2'd1, 2'd2, 8'hEB));
    rd(0, 32'h3C3_C3C3);
    wait_idle();
    repeat (4) step();

    summary();
    $finish;
  end

endmodule